// File: doc/BRIEF.md
# Restart Vector Interrupt Injector

This block sits next to a small 8-bit processor and turns up to eight external interrupt lines into one request to the core. Each request line that goes high is remembered in a pending register. While the processor's interrupt-enable output is high and at least one line is pending, the block raises the request to the processor. It needs no bus activity to do so, so a halted core can be woken by it.

The processor answers with an acknowledge fetch. The acknowledge flag (bit 0 of the status byte the system has captured) is high and the read strobe is active. During that fetch the block puts a one-byte restart opcode on the data bus. The opcode sends execution to a fixed vector at eight times the chosen index (0x0000 through 0x0038). The highest-numbered pending line is served first, and its pending bit is cleared as its byte is driven. Outside the acknowledge read, the data output is high-impedance.

Top module: `rst_vec_injector`

## Requirements
- R1: The driven byte for vector index n (0 to 7) is binary 11nnn111, equal to 0xC7 + 8*n, which sends the processor to address 8*n.
- R2: When several lines are pending, the one with the highest index is served first.
- R3: A line that is high on a clock edge becomes pending. From the next cycle `int_req` is high while `cpu_int_en` is high, without any bus activity.
- R4: `int_req` is never high while `cpu_int_en` is low. A pending line is kept and raises `int_req` as soon as the enable returns.
- R5: `bus_oe` is high only while both `ack_stat` and `rd_stb` are high. At all other times it is low and `bus_data` is high-impedance.
- R6: The pending bit of the served line clears at the first cycle of the acknowledge read, and other pending lines stay pending. The byte stays constant for the whole read, even if a higher line is raised during it.
- R7: An acknowledge read with nothing pending drives 0xFF (vector 7) and leaves the pending set unchanged.
- R8: A synchronous reset clears every pending line, so `int_req` is low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | NUM_REQ | Interrupt request lines, index = vector number |
| cpu_int_en | input | 1 | Processor's interrupt-enable output |
| ack_stat | input | 1 | Latched acknowledge flag from the captured status byte |
| rd_stb | input | 1 | Processor read strobe, active high |
| int_req | output | 1 | Interrupt request to the processor |
| bus_data | output | 8 | Restart opcode, high-impedance when not driven |
| bus_oe | output | 1 | High while `bus_data` is driven |

## Verification
The bench builds the block with the default of eight request lines. This makes every one of the eight restart opcodes reachable, and with them the collision between vector 7 and the empty-acknowledge default byte. A scoreboard queues the expected opcode for each acknowledge read and compares it when the drive enable rises. Directed cases cover the enable gating, a higher request arriving in the middle of a read, an empty acknowledge followed by a real one, and a reset that discards pending lines.

// File: rtl/rvi_pkg.sv
package rvi_pkg;
    localparam int VEC_MAX = 8;
    localparam int IDX_W   = $clog2(VEC_MAX);
    localparam int BYTE_W  = 8;

    typedef logic [IDX_W-1:0]  vec_idx_t;
    typedef logic [BYTE_W-1:0] op_byte_t;

    // Restart opcode: 11 nnn 111, target address = n * 8
    function automatic op_byte_t restart_byte(vec_idx_t idx);
        return {2'b11, idx, 3'b111};
    endfunction
endpackage

// File: rtl/rvi_prio_enc.sv
module rvi_prio_enc
    import rvi_pkg::*;
#(
    parameter int NUM_REQ = 8
) (
    input  logic [NUM_REQ-1:0] req,
    output logic               any,
    output vec_idx_t           idx
);
    // Ascending scan: a later (higher) index overwrites, so the highest wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rvi_bus_drv.sv
module rvi_bus_drv
    import rvi_pkg::*;
(
    input  logic     en,
    input  op_byte_t val,
    output op_byte_t bus
);
    assign bus = en ? val : {BYTE_W{1'bz}};
endmodule

// File: rtl/rst_vec_injector.sv
module rst_vec_injector
    import rvi_pkg::*;
#(
    parameter int NUM_REQ = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] irq_in,
    input  logic               cpu_int_en,
    input  logic               ack_stat,
    input  logic               rd_stb,
    output logic               int_req,
    output logic [7:0]         bus_data,
    output logic               bus_oe
);
    localparam vec_idx_t IDLE_VEC = vec_idx_t'(VEC_MAX - 1);

    typedef struct packed {
        logic [NUM_REQ-1:0] pend;
        logic               locked;
        vec_idx_t           vec;
    } st_t;

    st_t      st_d, st_q;
    logic     win_any;
    vec_idx_t win_idx;
    vec_idx_t sel_idx;
    logic     ack_rd;
    op_byte_t op_val;

    rvi_prio_enc #(.NUM_REQ(NUM_REQ)) u_prio (
        .req (st_q.pend),
        .any (win_any),
        .idx (win_idx)
    );

    always_comb begin
        ack_rd  = ack_stat & rd_stb;
        sel_idx = st_q.locked ? st_q.vec : (win_any ? win_idx : IDLE_VEC);
        op_val  = restart_byte(sel_idx);
        int_req = cpu_int_en & (|st_q.pend);

        st_d      = st_q;
        st_d.pend = st_q.pend | irq_in;
        if (ack_rd) begin
            if (!st_q.locked) begin
                st_d.locked = 1'b1;
                st_d.vec    = sel_idx;
                for (int i = 0; i < NUM_REQ; i++) begin
                    if (win_any && win_idx == IDX_W'(i)) begin
                        st_d.pend[i] = 1'b0;
                    end
                end
            end
        end else begin
            st_d.locked = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_oe = ack_rd;

    rvi_bus_drv u_drv (
        .en  (ack_rd),
        .val (op_val),
        .bus (bus_data)
    );
endmodule

// File: rtl/rvi_checker.sv
module rvi_checker #(
    parameter int NUM_REQ = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] irq_in,
    input logic               cpu_int_en,
    input logic               ack_stat,
    input logic               rd_stb,
    input logic               int_req,
    input logic [7:0]         bus_data,
    input logic               bus_oe
);
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
        int_req |-> cpu_int_en); // R4

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(ack_stat && rd_stb) |-> !bus_oe); // R5

    AST_OPCODE_FORM: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (bus_data[7:6] == 2'b11 && bus_data[2:0] == 3'b111)); // R1

    AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe) && !$past(rst)) |-> $stable(bus_data)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !int_req); // R8
endmodule

bind rst_vec_injector rvi_checker #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .cpu_int_en (cpu_int_en),
    .ack_stat   (ack_stat),
    .rd_stb     (rd_stb),
    .int_req    (int_req),
    .bus_data   (bus_data),
    .bus_oe     (bus_oe)
);

// File: tb/rst_vec_injector_tb.sv
module rst_vec_injector_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic         cpu_int_en = 1'b0;
    logic         ack_stat = 1'b0;
    logic         rd_stb = 1'b0;
    logic         int_req;
    logic [7:0]   bus_data;
    logic         bus_oe;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    logic       prev_oe = 1'b0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    rst_vec_injector #(.NUM_REQ(N)) u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cpu_int_en(cpu_int_en),
        .ack_stat(ack_stat), .rd_stb(rd_stb), .int_req(int_req),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: on each rising drive enable, pop and compare the opcode
    always @(negedge clk) begin
        #1;
        if (bus_oe === 1'b1 && prev_oe !== 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected drive", 8'h01, 8'h00);
            end else begin
                check("R1/R2 opcode", bus_data, exp_q.pop_front());
            end
        end
        prev_oe = bus_oe;
    end

    task automatic pulse(logic [N-1:0] m);
        @(negedge clk); irq_in = m;
        @(negedge clk); irq_in = '0;
    endtask

    // Driver: pushes the expected opcode, then runs a 3-cycle acknowledge read
    task automatic ack_read(logic [7:0] exp);
        @(negedge clk);
        exp_q.push_back(exp);
        ack_stat = 1'b1; rd_stb = 1'b1;
        repeat (3) @(negedge clk);
        ack_stat = 1'b0; rd_stb = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] op_of(int n);
        return 8'hC7 + 8'(8 * n);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R8 reset int_req", {7'd0, int_req}, 8'h00);
        check("R5 reset oe", {7'd0, bus_oe}, 8'h00);
        check("R5 reset highz", (bus_data === 8'hzz) ? 8'h1 : 8'h0, 8'h1);
        @(negedge clk); rst = 1'b0; cpu_int_en = 1'b1;

        // R3: single request wakes, no bus activity
        pulse(8'b0000_1000);
        #1 check("R3 int_req raised", {7'd0, int_req}, 8'h01);
        ack_read(op_of(3));
        #1 check("R6 served cleared", {7'd0, int_req}, 8'h00);

        // R2: two lines, highest first, lower stays pending
        pulse(8'b0100_0010);
        ack_read(op_of(6));
        #1 check("R6 other still pending", {7'd0, int_req}, 8'h01);
        ack_read(op_of(1));
        #1 check("R6 all served", {7'd0, int_req}, 8'h00);

        // R4: enable gating
        @(negedge clk); cpu_int_en = 1'b0;
        pulse(8'b0000_0100);
        #1 check("R4 gated low", {7'd0, int_req}, 8'h00);
        @(negedge clk); cpu_int_en = 1'b1;
        #1 check("R4 request kept", {7'd0, int_req}, 8'h01);
        ack_read(op_of(2));

        // R6: higher line arrives mid-read, byte stays
        pulse(8'b0000_0001);
        @(negedge clk);
        exp_q.push_back(op_of(0));
        ack_stat = 1'b1; rd_stb = 1'b1;
        @(negedge clk); irq_in = 8'b1000_0000;
        #1 check("R6 byte held", bus_data, op_of(0));
        @(negedge clk); irq_in = '0;
        #1 check("R6 byte held late", bus_data, op_of(0));
        @(negedge clk); ack_stat = 1'b0; rd_stb = 1'b0;
        #1 check("R6 new line pending", {7'd0, int_req}, 8'h01);
        ack_read(op_of(7));

        // R7: empty acknowledge, then a real one
        ack_read(8'hFF);
        #1 check("R7 nothing pending", {7'd0, int_req}, 8'h00);
        pulse(8'b0001_0000);
        ack_read(op_of(4));

        // R5: half strobes do not drive
        @(negedge clk); ack_stat = 1'b1;
        #1 check("R5 ack only", {7'd0, bus_oe}, 8'h00);
        check("R5 ack only highz", (bus_data === 8'hzz) ? 8'h1 : 8'h0, 8'h1);
        @(negedge clk); ack_stat = 1'b0; rd_stb = 1'b1;
        #1 check("R5 rd only", {7'd0, bus_oe}, 8'h00);
        @(negedge clk); rd_stb = 1'b0;

        // R8: reset drops pending lines
        pulse(8'b0010_0000);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check("R8 pending cleared", {7'd0, int_req}, 8'h00);
        ack_read(8'hFF);

        // R1: every vector
        for (int n = 0; n < N; n++) begin
            pulse(8'(1 << n));
            ack_read(op_of(n));
        end

        repeat (2) @(negedge clk);
        check("R1 queue drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule